// File: doc/BRIEF.md
# Prioritized ADC Trigger Chain Sequencer

This block sits in front of an analog-to-digital converter and turns trigger events into ordered sequences of conversion commands. There are ten trigger sources. Sources 0 to 7 can each be fired from a hardware input or, in software mode, from a one-cycle software strobe. Sources 8 and 9 accept hardware input only. Every source has its own enable. Fired sources are latched as pending, and an arbiter picks the next one to serve by a 3-bit priority.

The winning source runs its chain of one to eight segments. The sequencer waits an initial delay, then issues one conversion request per segment, carrying a channel number and a command-register select. It then waits for the converter's done handshake. Later segments either start straight away (back-to-back) or after an interval delay. Both delays are counted in ticks of a pre-divided clock. When a segment's conversion completes, it can raise one of three done events.

Top module: `trig_chain_seq`

## Requirements
- R1: A delay tick occurs once every (div_cfg+1) clock cycles, counted by a free-running prescaler that starts from zero after reset. A delay value of D ticks ends once D ticks have been counted since the wait began; D = 0 ends it in the first waiting cycle.
- R2: After a source is granted, the first conversion request of its chain follows its initial delay (init_dly). The back-to-back bit of segment 0 has no effect.
- R3: The length field encodes segments minus one. A chain with len_cfg = L issues exactly L+1 requests, for segments 0 to L in order.
- R4: When segment s+1 has its back-to-back bit set, its request is issued in the cycle right after the cycle in which adc_done completed segment s. When the bit is clear, the request follows gap_dly ticks.
- R5: Among pending sources, the one with the highest prio_cfg value (7 highest, 0 lowest) is granted next.
- R6: Pending sources of equal priority are granted lowest index first.
- R7: For sources 0 to 7, trig_en bit n gates source n. sw_mode bit n = 1 selects sw_trig as the source's trigger; 0 selects hw_trig. The unselected input and any disabled source have no effect.
- R8: Sources 8 and 9 respond only to hw_trig bits 8 and 9, gated by hw_only_en bits 0 and 1.
- R9: A segment's 2-bit interrupt code selects its done event: 0 none, 1 done_evt[0], 2 done_evt[1], 3 done_evt[2]. The selected event pulses for one cycle, in the cycle after the adc_done that completes the segment.
- R10: While soft_rst is high, all state is held in reset: no request, no done event, no pending source. Triggers that arrive during that time are lost.
- R11: A trigger for a source whose chain is running is latched and served again after that chain ends.
- R12: conv_valid is a one-cycle pulse carrying conv_ch, conv_sel and conv_src of the current segment. adc_done is ignored unless the sequencer is waiting for a conversion. After reset, outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous hold-in-reset |
| div_cfg | input | 8 | Prescaler divide value minus one |
| trig_en | input | 8 | Enable for sources 0 to 7 |
| sw_mode | input | 8 | Software mode select for sources 0 to 7 |
| hw_only_en | input | 2 | Enable for sources 8 and 9 |
| hw_trig | input | 10 | Hardware trigger strobes, one per source |
| sw_trig | input | 8 | Self-clearing software trigger strobes |
| prio_cfg | input | 30 | 3-bit priority per source |
| len_cfg | input | 30 | 3-bit chain length minus one per source |
| init_dly | input | 80 | 8-bit initial delay per source, in ticks |
| gap_dly | input | 80 | 8-bit interval delay per source, in ticks |
| seg_b2b | input | 80 | Back-to-back bit per source and segment |
| seg_ch | input | 560 | 7-bit channel per source and segment |
| seg_sel | input | 320 | 4-bit command select per source and segment |
| seg_irq | input | 160 | 2-bit done-event code per source and segment |
| adc_done | input | 1 | Conversion complete pulse |
| conv_valid | output | 1 | Conversion request pulse |
| conv_ch | output | 7 | Channel of the request |
| conv_sel | output | 4 | Command select of the request |
| conv_src | output | 4 | Source index of the running chain |
| done_evt | output | 3 | Done event pulses |

## Verification
The hardest case to reach is a source firing again while its own chain is still running. It must land in the pending latch without disturbing the running segment, and then be granted again once the chain returns to idle. The stimulus starts a four-segment back-to-back chain and pulses the same source's software strobe a few cycles into it. It then expects eight requests in total. A behavioural cycle model in the bench follows the prescaler phase, the delay waits and the handshake, and compares requests and done events on every clock.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP
  } seq_state_e;

  // 2-bit event code to one-hot done event
  function automatic logic [2:0] evt_decode(input logic [1:0] code);
    logic [2:0] r;
    case (code)
      2'd1:    r = 3'b001;
      2'd2:    r = 3'b010;
      2'd3:    r = 3'b100;
      default: r = 3'b000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/seq_prescaler.sv
module seq_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/seq_pending.sv
module seq_pending #(
  parameter int NSW   = 8,
  parameter int NHW   = 2,
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NSW-1:0]     trig_en,
  input  logic [NSW-1:0]     sw_mode,
  input  logic [NHW-1:0]     hw_only_en,
  input  logic [NSW+NHW-1:0] hw_trig,
  input  logic [NSW-1:0]     sw_trig,
  input  logic               grant_v,
  input  logic [IDX_W-1:0]   grant_idx,
  output logic [NSW+NHW-1:0] pend
);
  localparam int NT = NSW + NHW;

  logic [NT-1:0] ev;
  logic [NT-1:0] gmask;
  logic [NT-1:0] pend_q;

  for (genvar n = 0; n < NSW; n++) begin : g_mixed
    assign ev[n] = trig_en[n] && (sw_mode[n] ? sw_trig[n] : hw_trig[n]);
  end
  for (genvar n = 0; n < NHW; n++) begin : g_hwonly
    assign ev[NSW+n] = hw_only_en[n] && hw_trig[NSW+n];
  end

  always_comb begin
    gmask = '0;
    if (grant_v) gmask[grant_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (clr) pend_q <= '0;
    else          pend_q <= (pend_q & ~gmask) | ev;
  end

  assign pend = pend_q;
endmodule

// File: rtl/seq_arbiter.sv
module seq_arbiter #(
  parameter int NT    = 10,
  parameter int PRI_W = 3,
  parameter int IDX_W = 4
) (
  input  logic [NT-1:0]       pend,
  input  logic [NT*PRI_W-1:0] prio,
  output logic                any,
  output logic [IDX_W-1:0]    win
);
  logic [PRI_W-1:0] best;

  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    any  = 1'b0;
    best = '0;
    win  = '0;
    for (int n = NT - 1; n >= 0; n--) begin
      if (pend[n] && (!any || prio[n*PRI_W +: PRI_W] >= best)) begin
        any  = 1'b1;
        best = prio[n*PRI_W +: PRI_W];
        win  = IDX_W'(n);
      end
    end
  end
endmodule

// File: rtl/trig_chain_seq.sv
module trig_chain_seq #(
  parameter int NSW   = 8,
  parameter int NHW   = 2,
  parameter int NSEG  = 8,
  parameter int PRI_W = 3,
  parameter int DIV_W = 8,
  parameter int DLY_W = 8,
  parameter int CH_W  = 7,
  parameter int SEL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          soft_rst,
  input  logic [DIV_W-1:0]              div_cfg,
  input  logic [NSW-1:0]                trig_en,
  input  logic [NSW-1:0]                sw_mode,
  input  logic [NHW-1:0]                hw_only_en,
  input  logic [NSW+NHW-1:0]            hw_trig,
  input  logic [NSW-1:0]                sw_trig,
  input  logic [(NSW+NHW)*PRI_W-1:0]    prio_cfg,
  input  logic [(NSW+NHW)*$clog2(NSEG)-1:0] len_cfg,
  input  logic [(NSW+NHW)*DLY_W-1:0]    init_dly,
  input  logic [(NSW+NHW)*DLY_W-1:0]    gap_dly,
  input  logic [(NSW+NHW)*NSEG-1:0]     seg_b2b,
  input  logic [(NSW+NHW)*NSEG*CH_W-1:0]  seg_ch,
  input  logic [(NSW+NHW)*NSEG*SEL_W-1:0] seg_sel,
  input  logic [(NSW+NHW)*NSEG*2-1:0]     seg_irq,
  input  logic                          adc_done,
  output logic                          conv_valid,
  output logic [CH_W-1:0]               conv_ch,
  output logic [SEL_W-1:0]              conv_sel,
  output logic [$clog2(NSW+NHW)-1:0]    conv_src,
  output logic [2:0]                    done_evt
);
  import seq_pkg::*;

  localparam int NT    = NSW + NHW;
  localparam int IDX_W = $clog2(NT);
  localparam int SEG_W = $clog2(NSEG);

  seq_state_e       state_q;
  logic [IDX_W-1:0] act_q;
  logic [SEG_W-1:0] seg_q;
  logic [DLY_W-1:0] dcnt_q;
  logic [2:0]       done_q;

  logic             tick;
  logic [NT-1:0]    pend_q;
  logic             grant_any;
  logic [IDX_W-1:0] win_idx;
  logic             grant_v;
  logic             awaiting_done;
  logic             seg_complete;
  logic             chain_last;

  logic [SEG_W-1:0] seg_nx;
  int               cur_i;
  int               nxt_i;
  logic [SEG_W-1:0] cur_len;
  logic [DLY_W-1:0] cur_init;
  logic [DLY_W-1:0] cur_gap;
  logic             nxt_b2b;
  logic [1:0]       cur_irq;

  seq_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst), .div(div_cfg), .tick(tick)
  );

  seq_pending #(.NSW(NSW), .NHW(NHW), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst),
    .trig_en(trig_en), .sw_mode(sw_mode), .hw_only_en(hw_only_en),
    .hw_trig(hw_trig), .sw_trig(sw_trig),
    .grant_v(grant_v), .grant_idx(win_idx), .pend(pend_q)
  );

  seq_arbiter #(.NT(NT), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_arb (
    .pend(pend_q), .prio(prio_cfg), .any(grant_any), .win(win_idx)
  );

  // field selection for the running chain
  always_comb begin
    seg_nx   = seg_q + 1'b1;
    cur_i    = int'(act_q) * NSEG + int'(seg_q);
    nxt_i    = int'(act_q) * NSEG + int'(seg_nx);
    cur_len  = len_cfg[int'(act_q)*SEG_W +: SEG_W];
    cur_init = init_dly[int'(act_q)*DLY_W +: DLY_W];
    cur_gap  = gap_dly[int'(act_q)*DLY_W +: DLY_W];
    nxt_b2b  = seg_b2b[nxt_i];
    cur_irq  = seg_irq[cur_i*2 +: 2];
  end

  // named internal events
  assign grant_v       = (state_q == ST_IDLE) && grant_any;
  assign awaiting_done = (state_q == ST_WAIT);
  assign seg_complete  = awaiting_done && adc_done;
  assign chain_last    = (seg_q == cur_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      seg_q   <= '0;
      dcnt_q  <= '0;
    end else if (soft_rst) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      seg_q   <= '0;
      dcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (grant_any) begin
          act_q   <= win_idx;
          seg_q   <= '0;
          dcnt_q  <= '0;
          state_q <= ST_INIT;
        end
        ST_INIT: begin
          if (dcnt_q >= cur_init) state_q <= ST_ISSUE;
          else if (tick)          dcnt_q  <= dcnt_q + 1'b1;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (adc_done) begin
          if (chain_last) begin
            state_q <= ST_IDLE;
          end else begin
            seg_q   <= seg_nx;
            dcnt_q  <= '0;
            state_q <= nxt_b2b ? ST_ISSUE : ST_GAP;
          end
        end
        ST_GAP: begin
          if (dcnt_q >= cur_gap) state_q <= ST_ISSUE;
          else if (tick)         dcnt_q  <= dcnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            done_q <= '0;
    else if (soft_rst)     done_q <= '0;
    else if (seg_complete) done_q <= evt_decode(cur_irq);
    else                   done_q <= '0;
  end

  assign conv_valid = (state_q == ST_ISSUE);
  assign conv_ch    = seg_ch[cur_i*CH_W +: CH_W];
  assign conv_sel   = seg_sel[cur_i*SEL_W +: SEL_W];
  assign conv_src   = act_q;
  assign done_evt   = done_q;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int NT    = 10,
  parameter int PRI_W = 3,
  parameter int IDX_W = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                soft_rst,
  input logic                conv_valid,
  input logic [2:0]          done_evt,
  input logic                adc_done,
  input logic                awaiting_done,
  input logic                grant_v,
  input logic [IDX_W-1:0]    win_idx,
  input logic [NT-1:0]       pend,
  input logic [NT*PRI_W-1:0] prio_cfg
);
  logic             outranked;
  logic             tie_lower;
  logic [PRI_W-1:0] wp;

  always_comb begin
    outranked = 1'b0;
    tie_lower = 1'b0;
    wp = prio_cfg[int'(win_idx)*PRI_W +: PRI_W];
    for (int j = 0; j < NT; j++) begin
      if (pend[j] && prio_cfg[j*PRI_W +: PRI_W] > wp) outranked = 1'b1;
      if (pend[j] && prio_cfg[j*PRI_W +: PRI_W] == wp && j < int'(win_idx))
        tie_lower = 1'b1;
    end
  end

  a_r12_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_valid |=> !conv_valid);

  a_r9_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_evt));

  a_r9_done_after_adc: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_evt) |-> $past(adc_done && awaiting_done));

  a_r10_soft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!conv_valid && done_evt == 3'b000));

  a_r5_grant_top: assert property (@(posedge clk) disable iff (!rst_n)
    grant_v |-> !outranked);

  a_r6_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
    grant_v |-> !tie_lower);
endmodule

bind trig_chain_seq seq_chk #(.NT(NT), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
  .conv_valid(conv_valid), .done_evt(done_evt), .adc_done(adc_done),
  .awaiting_done(awaiting_done), .grant_v(grant_v), .win_idx(win_idx),
  .pend(pend_q), .prio_cfg(prio_cfg)
);

// File: tb/sim_trig_chain_seq.sv
module sim_trig_chain_seq;
  localparam int NT = 10;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [7:0] div_cfg = '0;
  logic [7:0] trig_en = '0;
  logic [7:0] sw_mode = '0;
  logic [1:0] hw_only_en = '0;
  logic [9:0] hw_trig = '0;
  logic [7:0] sw_trig = '0;
  logic [29:0] prio_cfg, len_cfg;
  logic [79:0] init_dly, gap_dly, seg_b2b;
  logic [559:0] seg_ch;
  logic [319:0] seg_sel;
  logic [159:0] seg_irq;
  logic resp_done = 1'b0;
  logic stray_done = 1'b0;
  logic adc_done;
  logic conv_valid;
  logic [6:0] conv_ch;
  logic [3:0] conv_sel;
  logic [3:0] conv_src;
  logic [2:0] done_evt;

  int pri_a [NT];
  int len_a [NT];
  int idly_a [NT];
  int gap_a [NT];
  int b2b_a [NT][NS];
  int irq_a [NT][NS];

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  string cur_req = "R12";
  int req_cnt = 0;
  int dcnt [3];
  int ch_log [$];
  int lat_cnt = -1;

  always #4 clk = ~clk;
  assign adc_done = resp_done | stray_done;

  always_comb begin
    for (int n = 0; n < NT; n++) begin
      prio_cfg[n*3 +: 3] = 3'(pri_a[n]);
      len_cfg[n*3 +: 3]  = 3'(len_a[n]);
      init_dly[n*8 +: 8] = 8'(idly_a[n]);
      gap_dly[n*8 +: 8]  = 8'(gap_a[n]);
      for (int s = 0; s < NS; s++) begin
        seg_b2b[n*NS+s]           = b2b_a[n][s] != 0;
        seg_ch[(n*NS+s)*7 +: 7]   = 7'(n*8 + s);
        seg_sel[(n*NS+s)*4 +: 4]  = 4'(s + 1);
        seg_irq[(n*NS+s)*2 +: 2]  = 2'(irq_a[n][s]);
      end
    end
  end

  trig_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .div_cfg(div_cfg),
    .trig_en(trig_en), .sw_mode(sw_mode), .hw_only_en(hw_only_en),
    .hw_trig(hw_trig), .sw_trig(sw_trig), .prio_cfg(prio_cfg),
    .len_cfg(len_cfg), .init_dly(init_dly), .gap_dly(gap_dly),
    .seg_b2b(seg_b2b), .seg_ch(seg_ch), .seg_sel(seg_sel), .seg_irq(seg_irq),
    .adc_done(adc_done), .conv_valid(conv_valid), .conv_ch(conv_ch),
    .conv_sel(conv_sel), .conv_src(conv_src), .done_evt(done_evt)
  );

  // ---------------- behavioural reference model ----------------
  int m_phase, m_mode, m_act, m_seg, m_wait;
  int m_pend [NT];
  int m_done;

  function automatic int evt_bits(int code);
    return (code == 0) ? 0 : (1 << (code - 1));
  endfunction

  function automatic bit fired(int n);
    if (n < 8) return trig_en[n] && (sw_mode[n] ? sw_trig[n] : hw_trig[n]);
    return hw_only_en[n-8] && hw_trig[n];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      m_phase = 0; m_mode = 0; m_act = 0; m_seg = 0; m_wait = 0; m_done = 0;
      foreach (m_pend[n]) m_pend[n] = 0;
    end else begin
      bit tk;
      int taken;
      int ev [NT];
      tk = (m_phase >= int'(div_cfg));
      m_phase = tk ? 0 : m_phase + 1;
      for (int n = 0; n < NT; n++) ev[n] = fired(n);
      taken = -1;
      m_done = (m_mode == 3 && adc_done) ? evt_bits(irq_a[m_act][m_seg]) : 0;
      case (m_mode)
        0: begin
          for (int n = 0; n < NT; n++)
            if (m_pend[n] != 0 && (taken < 0 || pri_a[n] > pri_a[taken])) taken = n;
          if (taken >= 0) begin
            m_act = taken; m_seg = 0; m_wait = 0; m_mode = 1;
          end
        end
        1: if (m_wait >= idly_a[m_act]) m_mode = 2; else if (tk) m_wait++;
        2: m_mode = 3;
        3: if (adc_done) begin
          if (m_seg == len_a[m_act]) m_mode = 0;
          else begin
            m_seg++; m_wait = 0;
            m_mode = (b2b_a[m_act][m_seg] != 0) ? 2 : 4;
          end
        end
        default: if (m_wait >= gap_a[m_act]) m_mode = 2; else if (tk) m_wait++;
      endcase
      for (int n = 0; n < NT; n++)
        m_pend[n] = ((m_pend[n] != 0 && n != taken) || ev[n] != 0) ? 1 : 0;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      bit mv;
      mv = (m_mode == 2);
      vectors++;
      if (conv_valid !== mv || done_evt !== 3'(m_done) ||
          (mv && (conv_ch !== 7'(m_act*8 + m_seg) || conv_sel !== 4'(m_seg + 1)
                  || conv_src !== 4'(m_act)))) begin
        fails++;
        $display("FAIL %s: valid=%0b ch=%0d sel=%0d src=%0d done=%b expected valid=%0b ch=%0d sel=%0d src=%0d done=%b",
                 cur_req, conv_valid, conv_ch, conv_sel, conv_src, done_evt,
                 mv, m_act*8+m_seg, m_seg+1, m_act, 3'(m_done));
      end
      if (conv_valid === 1'b1) begin req_cnt++; ch_log.push_back(int'(conv_ch)); end
      for (int k = 0; k < 3; k++) if (done_evt[k] === 1'b1) dcnt[k]++;
    end
  end

  // converter responder: done 3 cycles after each request
  always @(negedge clk) begin
    resp_done = 1'b0;
    if (lat_cnt > 0) lat_cnt--;
    if (lat_cnt == 0) begin resp_done = 1'b1; lat_cnt = -1; end
    if (conv_valid === 1'b1) lat_cnt = 3;
  end

  task automatic check_int(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_cfg();
    trig_en = '0; sw_mode = '0; hw_only_en = '0; div_cfg = '0;
    for (int n = 0; n < NT; n++) begin
      pri_a[n] = 0; len_a[n] = 0; idly_a[n] = 0; gap_a[n] = 0;
      for (int s = 0; s < NS; s++) begin b2b_a[n][s] = 0; irq_a[n][s] = 0; end
    end
  endtask

  task automatic start_count();
    req_cnt = 0; dcnt[0] = 0; dcnt[1] = 0; dcnt[2] = 0; ch_log.delete();
  endtask

  task automatic pulse_sw(int n);
    @(negedge clk); sw_trig[n] = 1'b1;
    @(negedge clk); sw_trig[n] = 1'b0;
  endtask

  task automatic pulse_hw(int n);
    @(negedge clk); hw_trig[n] = 1'b1;
    @(negedge clk); hw_trig[n] = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    clear_cfg();
    idle(3);
    // R12: reset state
    check_int("R12", "conv_valid in reset", int'(conv_valid), 0);
    check_int("R12", "done_evt in reset", int'(done_evt), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    // R1 R2 R3 R4 R9: one chain with delays, gap and back-to-back
    cur_req = "R1 R2 R3 R4 R9";
    div_cfg = 8'd2; trig_en[0] = 1'b1; sw_mode[0] = 1'b1;
    len_a[0] = 2; idly_a[0] = 2; gap_a[0] = 3; b2b_a[0][2] = 1; b2b_a[0][0] = 1;
    irq_a[0][0] = 1; irq_a[0][1] = 2; irq_a[0][2] = 3;
    start_count();
    pulse_sw(0);
    idle(120);
    check_int("R3", "requests for length field 2", req_cnt, 3);
    check_int("R9", "done_evt[0] count", dcnt[0], 1);
    check_int("R9", "done_evt[1] count", dcnt[1], 1);
    check_int("R9", "done_evt[2] count", dcnt[2], 1);

    // R5 R6: priority and tie order
    cur_req = "R5 R6";
    clear_cfg();
    trig_en[2] = 1'b1; trig_en[5] = 1'b1; sw_mode[2] = 1'b1; sw_mode[5] = 1'b1;
    hw_only_en[1] = 1'b1;
    pri_a[2] = 3; pri_a[5] = 6; pri_a[9] = 6;
    start_count();
    @(negedge clk); sw_trig[2] = 1'b1; sw_trig[5] = 1'b1; hw_trig[9] = 1'b1;
    @(negedge clk); sw_trig = '0; hw_trig = '0;
    idle(60);
    check_int("R5", "grant count", ch_log.size(), 3);
    if (ch_log.size() == 3) begin
      check_int("R6", "first channel (tie, lower index)", ch_log[0], 40);
      check_int("R6", "second channel", ch_log[1], 72);
      check_int("R5", "last channel (lowest priority)", ch_log[2], 16);
    end

    // R7: enable and mode gating
    cur_req = "R7 R8";
    clear_cfg();
    sw_mode[3] = 1'b1;
    start_count();
    pulse_sw(3); pulse_hw(3); idle(20);
    check_int("R7", "disabled source requests", req_cnt, 0);
    trig_en[4] = 1'b1;
    pulse_sw(4); idle(20);
    check_int("R7", "hw-mode source after sw strobe", req_cnt, 0);
    pulse_hw(4); idle(20);
    check_int("R7", "hw-mode source after hw strobe", req_cnt, 1);
    // R8: hardware-only sources
    start_count();
    pulse_hw(8); idle(20);
    check_int("R8", "source 8 while disabled", req_cnt, 0);
    hw_only_en[0] = 1'b1;
    pulse_hw(8); idle(20);
    check_int("R8", "source 8 while enabled", req_cnt, 1);

    // R10: soft reset mid-chain
    cur_req = "R10";
    clear_cfg();
    div_cfg = 8'd1; trig_en[6] = 1'b1; sw_mode[6] = 1'b1;
    len_a[6] = 7; idly_a[6] = 3; gap_a[6] = 3;
    pulse_sw(6);
    idle(20);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); sw_trig[6] = 1'b1;
    @(negedge clk); sw_trig[6] = 1'b0;
    @(negedge clk); soft_rst = 1'b0;
    start_count();
    idle(200);
    check_int("R10", "requests after soft reset", req_cnt, 0);

    // R11: re-trigger while running
    cur_req = "R11";
    clear_cfg();
    trig_en[1] = 1'b1; sw_mode[1] = 1'b1;
    len_a[1] = 3; idly_a[1] = 1;
    for (int s = 0; s < NS; s++) b2b_a[1][s] = 1;
    start_count();
    pulse_sw(1);
    idle(4);
    pulse_sw(1);
    idle(80);
    check_int("R11", "requests for two chains", req_cnt, 8);

    // R12: stray converter done while idle
    cur_req = "R12";
    clear_cfg();
    trig_en[7] = 1'b1; sw_mode[7] = 1'b1; irq_a[7][0] = 2;
    start_count();
    @(negedge clk); stray_done = 1'b1;
    @(negedge clk); stray_done = 1'b0;
    idle(5);
    check_int("R12", "done events from stray done", dcnt[1], 0);
    pulse_sw(7);
    idle(30);
    check_int("R12", "requests", req_cnt, 1);
    check_int("R12", "done events", dcnt[1], 1);
    if (ch_log.size() > 0) check_int("R12", "channel", ch_log[0], 56);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule